// File: doc/BRIEF.md
# Programmable Countdown Timer

This block is a per-core countdown timer. Software loads a start value, and the count then falls by one on every prescaled clock tick. When the count reaches zero, the block sends a one-cycle request that carries a programmed 8-bit vector. A prescaler divides the clock by a power of two. The divide setting is a 4-bit field whose three valid bits are not next to each other.

Two modes exist. In one-shot mode the count stops at zero and the request fires once. In periodic mode the count reloads the start value after it reaches zero, so the request repeats every start value + 1 ticks. A mask bit blocks the request but does not stop the count.

Top module: `countdown_timer`

## Requirements
- R1: After reset, the registers read as follows. Entry register (address 0) reads 0x0001_0000, which means the mask is set and the mode is one-shot. Start value (address 1), count (address 2) and divide (address 3) all read 0. `req_valid` is low.
- R2: A write to the divide register (address 3) keeps only bits 0, 1 and 3 (mask 0xB). The stored value reads back.
- R3: The divide setting gives a 3-bit code: divide bits 1:0 are the low bits and divide bit 3 is the top bit. The tick rate is clock / 2^((code+1) mod 8). For example, 0xB divides by 1 and 0x1 divides by 4.
- R4: A write to the start-value register (address 1) loads the count with that value. It also restarts the prescaler. This happens even if a countdown is already running.
- R5: In one-shot mode (entry bit 17 = 0), the count falls by one per tick and stays at 0. It sends exactly one request, on the tick that takes it from 1 to 0.
- R6: In periodic mode (entry bit 17 = 1), the count reloads the start value on the tick after it reaches 0. A request fires each time it reaches 0, every start value + 1 ticks.
- R7: When the entry mask bit (bit 16) is set, no request is sent. The countdown still runs.
- R8: A write to the count register (address 2) has no effect.
- R9: A start value of 0 stops the timer, and no request is sent.
- R10: A request is a single-cycle high pulse on `req_valid`. It carries the entry's vector (bits 7:0) on `req_vector`.
- R11: A new divide setting takes effect at the next prescaler boundary. The count is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register select: 0 entry, 1 start value, 2 count, 3 divide |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| req_valid | output | 1 | Expiry request pulse |
| req_vector | output | 8 | Vector sent with the request |

## Verification
Let W be the cycle in which a start-value write is first visible. The count then reads N - k at cycle W + k*2^s, where 2^s is the divide ratio. A request is seen at cycle W + N*2^s.

The driver task computes each expected request from these rules and pushes its cycle and vector into a queue. The monitor pops an entry whenever `req_valid` is high and compares the cycle and vector. Any request the queue did not expect is a failure. Count reads are sampled at chosen cycles counted from W, with all sampling on the falling edge.

// File: rtl/countdown_timer.sv
module countdown_timer #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        req_valid,
  output logic [VEC_W-1:0] req_vector
);
  localparam int PRE_W = 7;
  localparam logic [1:0] A_ENTRY = 2'd0, A_INIT = 2'd1, A_CUR = 2'd2, A_DIV = 2'd3;

  logic [VEC_W-1:0] vec_q;
  logic             mask_q, per_q;
  logic [CNT_W-1:0] init_q, cur_q;
  logic [3:0]       div_q;
  logic [2:0]       shift_q;
  logic [PRE_W-1:0] pre_q;

  wire [2:0]       div_code  = {div_q[3], div_q[1:0]};
  wire [2:0]       shift_new = div_code + 3'd1;
  wire [PRE_W-1:0] pre_lim   = ~({PRE_W{1'b1}} << shift_q);
  wire             tick      = (pre_q == pre_lim);
  wire             init_wr   = reg_wr && (reg_addr == A_INIT);
  wire             expire    = tick && !init_wr && (cur_q == CNT_W'(1));

  always_comb begin
    case (reg_addr)
      A_ENTRY: reg_rdata = {14'd0, per_q, mask_q, 8'd0, 8'(vec_q)};
      A_INIT:  reg_rdata = 32'(init_q);
      A_CUR:   reg_rdata = 32'(cur_q);
      default: reg_rdata = {28'd0, div_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q      <= '0;
      mask_q     <= 1'b1;
      per_q      <= 1'b0;
      init_q     <= '0;
      cur_q      <= '0;
      div_q      <= '0;
      shift_q    <= 3'd1;
      pre_q      <= '0;
      req_valid  <= 1'b0;
      req_vector <= '0;
    end else begin
      if (reg_wr && reg_addr == A_ENTRY) begin
        vec_q  <= reg_wdata[VEC_W-1:0];
        mask_q <= reg_wdata[16];
        per_q  <= reg_wdata[17];
      end
      if (reg_wr && reg_addr == A_DIV) div_q <= reg_wdata[3:0] & 4'hB;
      if (init_wr) begin
        init_q  <= reg_wdata[CNT_W-1:0];
        cur_q   <= reg_wdata[CNT_W-1:0];
        pre_q   <= '0;
        shift_q <= shift_new;
      end else if (tick) begin
        pre_q   <= '0;
        shift_q <= shift_new;
        if (cur_q != '0) cur_q <= cur_q - CNT_W'(1);
        else if (per_q)  cur_q <= init_q;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
      req_valid <= expire && !mask_q;
      if (expire) req_vector <= vec_q;
    end
  end

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);
  // R7
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !$past(mask_q));
  // R5
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_q && cur_q == '0 && !init_wr) |=> cur_q == '0);
  // R9
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q == '0) |=> !req_valid);
  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q <= init_q);
endmodule

// File: tb/test_countdown_timer.sv
module test_countdown_timer;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        req_valid;
  logic [7:0]  req_vector;
  int cyc = 0, checks = 0, fails = 0;
  int exp_cyc[$];
  logic [7:0] exp_vec[$];
  int w;

  countdown_timer i_countdown_timer (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_vector(req_vector));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, output int when);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0;
    when = cyc;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string req);
    reg_addr = a;
    #0.5;
    check(req, reg_rdata, exp);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_req(int c, logic [7:0] v);
    exp_cyc.push_back(c);
    exp_vec.push_back(v);
  endtask

  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      if (exp_cyc.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: unexpected request at cycle %0d vector %0h, expected none", cyc, req_vector);
      end else begin
        check("R10 request cycle", cyc, exp_cyc.pop_front());
        check("R10 request vector", {24'd0, req_vector}, {24'd0, exp_vec.pop_front()});
      end
    end
  end

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, 32'h0001_0000, "R1 entry");
    rd(1, 0, "R1 start");
    rd(2, 0, "R1 count");
    rd(3, 0, "R1 divide");
    check("R1 req_valid", {31'd0, req_valid}, 0);
    // R2 divide masking
    wr(3, 32'hFF, t);
    rd(3, 32'hB, "R2 divide mask");
    // R5 one-shot, divide 1 (R3)
    wr(0, 32'h41, t);
    wr(1, 5, w);
    expect_req(w + 5, 8'h41);
    rd(2, 5, "R4 count loaded");
    wait_until(w + 3); rd(2, 2, "R3 divide-by-1 count");
    wait_until(w + 12); rd(2, 0, "R5 count sticks at 0");
    // R3 divide by 4
    wr(3, 32'h1, t);
    wr(1, 3, w);
    expect_req(w + 12, 8'h41);
    wait_until(w + 3); rd(2, 3, "R3 before first tick");
    wait_until(w + 4); rd(2, 2, "R3 divide-by-4 tick");
    wait_until(w + 16); rd(2, 0, "R5 one-shot end");
    // R6 periodic
    wr(3, 32'hB, t);
    wr(0, 32'h0002_0077, t);
    wr(1, 2, w);
    expect_req(w + 2, 8'h77);
    expect_req(w + 5, 8'h77);
    expect_req(w + 8, 8'h77);
    wait_until(w + 3); rd(2, 2, "R6 reload");
    wait_until(w + 9);
    // R9 start value 0 stops
    wr(1, 0, t);
    wait_until(t + 20); rd(2, 0, "R9 stopped count");
    // R4 restart mid-countdown, one-shot
    wr(0, 32'h55, t);
    wr(1, 10, w);
    wait_until(w + 3);
    wr(1, 4, w);
    expect_req(w + 4, 8'h55);
    rd(2, 4, "R4 restart value");
    wait_until(w + 10);
    // R7 mask
    wr(0, 32'h0001_0066, t);
    wr(1, 3, w);
    wait_until(w + 2); rd(2, 1, "R7 masked still counts");
    wait_until(w + 8); rd(2, 0, "R7 masked reaches zero");
    // R8 count write ignored
    wr(0, 32'h33, t);
    wr(1, 20, w);
    expect_req(w + 20, 8'h33);
    wait_until(w + 4);
    wr(2, 5, t);
    rd(2, 20 - (t - w), "R8 count write ignored");
    wait_until(w + 25);
    // R11 divide change at boundary
    wr(3, 32'h1, t);
    wr(1, 4, w);
    expect_req(w + 10, 8'h33);
    wait_until(w + 5);
    wr(3, 32'hB, t);
    wait_until(w + 7); rd(2, 3, "R11 count kept");
    wait_until(w + 9); rd(2, 1, "R11 new divide applied");
    wait_until(w + 20);
    check("R10 all expected requests seen", exp_cyc.size(), 0);
    report();
  end
endmodule